// File: doc/BRIEF.md
# Pipelined Debug Value Snapshot Buffer

This block collects the current values of many debug sources and keeps a copy of each in a small dual-ported store. A video renderer can read that store at the dot rate. The sources are not read through one wide combinational selector. A scan index steps through them one per cycle. Each selected value passes through a radix-4 selection tree, with a register after every level, so the logic depth per cycle stays at one 4:1 selector no matter how many sources there are.

The write address to the store is the scan index, delayed by the same number of register levels as the data. The value captured for source k is therefore always written to entry k. A renderer on the second port presents any entry address and gets the stored value one cycle later, with no stall. A one-cycle completion pulse marks each pass in which every entry has been written once. The refresh rate is one full pass per NUM_SRC cycles, which is far slower than the dot rate but fast enough for a person watching a display. Both ports run on one clock.

Top module: `dbg_snap_top`

## Requirements
- R1: While rst_n is low, rd_data_o is 0 and scan_done_o is 0.
- R2: After reset the scan index starts at 0 and advances by one every cycle, returning to 0 after NUM_SRC-1.
- R3: The selection tree has LEVELS register stages. LEVELS is the smallest value of at least 1 with 4^LEVELS >= NUM_SRC (2 for the default of 10 sources). The value of source k, sampled at the clock edge that ends the cycle in which index k is issued, is written to entry k LEVELS cycles later. Source k occupies bits [k*DATA_W +: DATA_W] of src_vec_i.
- R4: scan_done_o is high for exactly one cycle, in the cycle in which entry NUM_SRC-1 is written. Counting the first cycle after reset release as cycle 0, the first pulse comes in cycle NUM_SRC-1+LEVELS. After that, pulses come every NUM_SRC cycles.
- R5: A read address presented in one cycle returns that entry's contents on rd_data_o in the next cycle. A new address may be presented every cycle.
- R6: When a read and a write target the same entry in the same cycle, the read returns the contents from before the write.
- R7: A read issued NUM_SRC+LEVELS cycles or more after a source changes (and with the source held since) returns the new value.
- R8: A read address of NUM_SRC or above returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the scan, the store and the read port |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_vec_i | input | NUM_SRC*DATA_W | Packed debug source values, source k in slice k |
| rd_addr_i | input | IDX_W | Video-side entry address |
| rd_data_o | output | DATA_W | Stored value, one cycle after the address |
| scan_done_o | output | 1 | One-cycle pulse when the last entry of a pass is written |

## Verification
On every cycle the assertions check that the scan index stays in range and steps in order, that consecutive write addresses follow each other, and the exact spacing of completion pulses, both the first one and the later ones. They also check that a read output holds steady while the same address is read and nothing writes to it. The bench scenarios cover the data itself. They check that each entry holds its own source's value and not a neighbour's, that the read-before-write ordering holds on a collision, that a changed source is reflected within the stated bound, and that out-of-range reads return zero.

// File: rtl/dbg_snap_pkg.sv
package dbg_snap_pkg;

  // number of radix-4 register levels needed to cover n sources
  function automatic int mux_levels(input int n);
    int lv;
    int span;
    lv   = 1;
    span = 4;
    while (span < n) begin
      span = span * 4;
      lv   = lv + 1;
    end
    return lv;
  endfunction

  // leaves of a full radix-4 tree of lv levels
  function automatic int leaf_count(input int lv);
    return 1 << (2 * lv);
  endfunction

  // width of an index over n entries
  function automatic int idx_bits(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // wrapping increment over 0..n-1
  function automatic int wrap_inc(input int v, input int n);
    return (v >= n - 1) ? 0 : v + 1;
  endfunction

endpackage

// File: rtl/snap_scan_ctr.sv
module snap_scan_ctr
  import dbg_snap_pkg::*;
#(
  parameter int NUM_SRC = 10,
  parameter int LEVELS  = 2,
  parameter int IDX_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [IDX_W-1:0] scan_idx_o,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_addr_o,
  output logic             scan_done_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SRC - 1);

  logic [IDX_W-1:0]             idx_q;
  logic [LEVELS-1:0]            vld_sr;
  logic [LEVELS-1:0][IDX_W-1:0] adr_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      vld_sr <= '0;
      adr_sr <= '0;
    end else begin
      idx_q     <= IDX_W'(wrap_inc(int'(idx_q), NUM_SRC));
      vld_sr[0] <= 1'b1;
      adr_sr[0] <= idx_q;
      for (int k = 1; k < LEVELS; k++) begin
        vld_sr[k] <= vld_sr[k-1];
        adr_sr[k] <= adr_sr[k-1];
      end
    end
  end

  assign scan_idx_o  = idx_q;
  assign wr_en_o     = vld_sr[LEVELS-1];
  assign wr_addr_o   = adr_sr[LEVELS-1];
  assign scan_done_o = wr_en_o && (wr_addr_o == LAST_IDX);

endmodule

// File: rtl/snap_mux_tree.sv
module snap_mux_tree
  import dbg_snap_pkg::*;
#(
  parameter int NUM_SRC = 10,
  parameter int DATA_W  = 16,
  parameter int LEVELS  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC*DATA_W-1:0] src_i,
  input  logic [2*LEVELS-1:0]       sel_i,
  output logic [DATA_W-1:0]         dat_o
);

  localparam int PAD = leaf_count(LEVELS);

  logic [PAD*DATA_W-1:0] pad_in;
  assign pad_in = (PAD*DATA_W)'(src_i);

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    localparam int IN_CNT = PAD >> (2 * l);
    localparam int CNT    = IN_CNT / 4;
    localparam int SW     = 2 * (LEVELS - l);

    logic [IN_CNT*DATA_W-1:0] d_in;
    logic [SW-1:0]            s_in;
    logic [CNT*DATA_W-1:0]    q;

    if (l == 0) begin : g_first
      assign d_in = pad_in;
      assign s_in = sel_i;
    end else begin : g_next
      assign d_in = g_lvl[l-1].q;
      assign s_in = g_lvl[l-1].g_sreg.s_q;
    end

    // one 4:1 choice per node, the low select digit picks within each group
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else begin
        for (int j = 0; j < CNT; j++) begin
          q[j*DATA_W +: DATA_W] <= d_in[(4*j + int'(s_in[1:0]))*DATA_W +: DATA_W];
        end
      end
    end

    // the remaining digits travel with the data to the next level
    if (l < LEVELS - 1) begin : g_sreg
      logic [SW-3:0] s_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_in[SW-1:2];
      end
    end
  end

  assign dat_o = g_lvl[LEVELS-1].q;

endmodule

// File: rtl/snap_dpram.sv
module snap_dpram #(
  parameter int DEPTH  = 10,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (wr_en_i) mem[wr_addr_i] <= wr_data_i;
  end

  // read samples the array before this edge's write lands: old data on collision
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       rd_q <= '0;
    else if (int'(rd_addr_i) < DEPTH) rd_q <= mem[rd_addr_i];
    else                              rd_q <= '0;
  end

  assign rd_data_o = rd_q;

endmodule

// File: rtl/dbg_snap_top.sv
module dbg_snap_top
  import dbg_snap_pkg::*;
#(
  parameter int NUM_SRC = 10,
  parameter int DATA_W  = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_SRC*DATA_W-1:0]      src_vec_i,
  input  logic [idx_bits(NUM_SRC)-1:0]   rd_addr_i,
  output logic [DATA_W-1:0]              rd_data_o,
  output logic                           scan_done_o
);

  localparam int LEVELS = mux_levels(NUM_SRC);
  localparam int IDX_W  = idx_bits(NUM_SRC);
  localparam int SEL_W  = 2 * LEVELS;

  logic [IDX_W-1:0]  scan_idx;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic              scan_done;

  snap_scan_ctr #(
    .NUM_SRC(NUM_SRC), .LEVELS(LEVELS), .IDX_W(IDX_W)
  ) scan_i (
    .clk(clk), .rst_n(rst_n), .scan_idx_o(scan_idx),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .scan_done_o(scan_done)
  );

  snap_mux_tree #(
    .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .LEVELS(LEVELS)
  ) tree_i (
    .clk(clk), .rst_n(rst_n), .src_i(src_vec_i),
    .sel_i(SEL_W'(scan_idx)), .dat_o(wr_data)
  );

  snap_dpram #(
    .DEPTH(NUM_SRC), .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) store_i (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
  );

  assign scan_done_o = scan_done;

endmodule

// File: rtl/snap_checker.sv
module snap_checker
  import dbg_snap_pkg::*;
#(
  parameter int NUM_SRC = 10,
  parameter int DATA_W  = 16,
  parameter int IDX_W   = 4,
  parameter int LEVELS  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [IDX_W-1:0]  scan_idx,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_addr,
  input logic              scan_done,
  input logic [IDX_W-1:0]  rd_addr,
  input logic [DATA_W-1:0] rd_data
);

  logic        alive;
  logic        seen;
  logic [1:0]  full_sr;
  logic [15:0] since_rst;
  logic [15:0] gap;
  logic        wr_hit;

  assign wr_hit = wr_en && (wr_addr == rd_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alive     <= 1'b0;
      seen      <= 1'b0;
      full_sr   <= '0;
      since_rst <= '0;
      gap       <= '0;
    end else begin
      alive     <= 1'b1;
      if (scan_done) seen <= 1'b1;
      full_sr   <= {full_sr[0], seen};
      if (since_rst != 16'hFFFF) since_rst <= since_rst + 16'd1;
      if (scan_done)             gap <= '0;
      else if (gap != 16'hFFFF)  gap <= gap + 16'd1;
    end
  end

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(scan_idx) < NUM_SRC); // R2

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    alive |-> int'(scan_idx) == wrap_inc(int'($past(scan_idx)), NUM_SRC)); // R2

  AST_WADDR_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (alive && wr_en && $past(wr_en)) |-> int'(wr_addr) == wrap_inc(int'($past(wr_addr)), NUM_SRC)); // R3

  AST_FIRST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_done && !seen) |-> int'(since_rst) == NUM_SRC - 1 + LEVELS); // R4

  AST_PULSE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_done && seen) |-> int'(gap) == NUM_SRC - 1); // R4

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (full_sr[1] && $past(rd_addr) == $past(rd_addr, 2) && !$past(wr_hit, 2)) |-> $stable(rd_data)); // R5

endmodule

bind dbg_snap_top snap_checker #(
  .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .IDX_W(IDX_W), .LEVELS(LEVELS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .scan_idx(scan_idx), .wr_en(wr_en),
  .wr_addr(wr_addr), .scan_done(scan_done), .rd_addr(rd_addr_i), .rd_data(rd_data_o)
);

// File: tb/dbg_snap_top_tb_top.sv
module dbg_snap_top_tb_top;

  localparam int N    = 10;
  localparam int DW   = 16;
  localparam int AW   = 4;
  localparam int AMAX = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N*DW-1:0] src_vec = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          scan_done;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [DW-1:0] model [N];
  int order [AMAX];

  always #2 clk = ~clk;  // 250 MHz

  dbg_snap_top #(.NUM_SRC(N), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_vec_i(src_vec), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .scan_done_o(scan_done)
  );

  // register levels derived from the radix-4 rule
  function automatic int tree_depth(input int n);
    int d = 0;
    int p = 1;
    while (p < n) begin p = p * 4; d++; end
    return (d == 0) ? 1 : d;
  endfunction

  function automatic logic [DW-1:0] exp_read(input int a);
    return (a < N) ? model[a] : '0;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive_sources();
    for (int k = 0; k < N; k++) src_vec[k*DW +: DW] = model[k];
  endtask

  task automatic randomize_model();
    for (int k = 0; k < N; k++) model[k] = DW'($urandom);
    drive_sources();
  endtask

  task automatic shuffle_order(input int cnt);
    for (int i = 0; i < cnt; i++) order[i] = i;
    for (int i = cnt - 1; i > 0; i--) begin
      int j;
      int t;
      j = int'($urandom % (i + 1));
      t = order[i]; order[i] = order[j]; order[j] = t;
    end
  endtask

  // back-to-back reads, one address per cycle, checked one cycle later
  task automatic read_list(input int cnt, input string tag);
    for (int i = 0; i <= cnt; i++) begin
      @(negedge clk);
      if (i > 0) check(rd_data == exp_read(order[i-1]), tag, rd_data, exp_read(order[i-1]));
      if (i < cnt) rd_addr = AW'(order[i]);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int lv;
    int cyc;
    logic [DW-1:0] v0;
    logic [DW-1:0] v1;
    void'($urandom(32'h5EED_1234));
    lv = tree_depth(N);
    randomize_model();

    // R1: reset state
    repeat (3) @(negedge clk);
    check(rd_data == '0, "R1 rd_data in reset", rd_data, 0);
    check(scan_done == 1'b0, "R1 scan_done in reset", scan_done, 0);
    rst_n = 1'b1;

    // R4/R3: first pulse position, cycle N-1+LV after release
    cyc = 0;
    while (!scan_done && cyc < 100) begin
      @(posedge clk); @(negedge clk); cyc++;
    end
    check(cyc == N - 1 + lv, "R4 first pulse cycle", cyc, N - 1 + lv);

    // R2/R4: next pulse exactly N cycles later, low in between
    cyc = 0;
    do begin @(posedge clk); @(negedge clk); cyc++; end while (!scan_done && cyc < 100);
    check(cyc == N, "R2 R4 pulse spacing", cyc, N);
    @(posedge clk); @(negedge clk);
    check(scan_done == 1'b0, "R4 pulse one cycle wide", scan_done, 0);

    // R3/R5: every entry holds its own source, random order
    shuffle_order(N);
    read_list(N, "R3 R5 entry contents");

    // R8: out-of-range addresses read zero
    for (int i = 0; i < AMAX - N; i++) order[i] = N + i;
    read_list(AMAX - N, "R8 out of range");

    // R7: several random source patterns, read after N+LV cycles
    for (int r = 0; r < 6; r++) begin
      @(negedge clk);
      randomize_model();
      if (r == 4) begin
        for (int k = 0; k < N; k++) model[k] = (k % 2 == 0) ? '1 : '0;
        drive_sources();
      end
      repeat (N + lv) @(posedge clk);
      shuffle_order(N);
      read_list(N, "R7 refresh bound");
    end

    // R6: collision on entry N-1 returns old contents, then new
    do @(negedge clk); while (!scan_done);
    v0 = model[N-1];
    v1 = v0 ^ 16'h5A3C;
    model[N-1] = v1;
    drive_sources();
    do begin @(posedge clk); @(negedge clk); end while (!scan_done);
    rd_addr = AW'(N - 1);
    @(negedge clk);
    check(rd_data == v0, "R6 read during write old data", rd_data, v0);
    @(negedge clk);
    check(rd_data == v1, "R6 value after write", rd_data, v1);

    // R5: held address keeps returning the same value
    rd_addr = 4'd3;
    @(negedge clk);
    @(negedge clk);
    check(rd_data == model[3], "R5 held address", rd_data, model[3]);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule